// File: doc/BRIEF.md
# Pointwise Channel-Mixing Accumulator

This unit produces one output channel of a 1×1 convolution. For each pixel, a stream delivers the values of every input channel, one channel per clock, and a flag marks the final channel. Each value is multiplied by the weight stored for its channel position in a local weight memory. The products are summed in a wide accumulator. When the final channel arrives, the unit adds a bias to the sum. It then rescales the result with a scale and an offset, saturates it to 16 bits and passes it through a selectable activation. One result per pixel appears on the output.

The unit has two input streams. One carries raw input channels and the other carries depthwise results. A configuration bit selects which stream the unit uses. In a larger design, many copies of this unit listen to the same stream and each copy holds its own weights. The channel count, the weights and the tail settings all load through a single load port. All data is signed Q8.8.

Top module: `pw_mac_unit`

## Requirements
- R1: After reset, `out_valid` and `out_err` are low and `out_data` is 0. The defaults are N=1, bias 0, scale 1.0 (0x0100), offset 0, activation pass, and the raw stream as source.
- R2: Each accepted beat multiplies its Q8.8 value by the weight at address equal to the beat's channel index. The products are summed in a 40-bit accumulator. The accumulator starts afresh on channel index 0 of every pixel, so no part of one pixel's sum carries into the next.
- R3: `out_valid` is high for exactly one cycle: the cycle after a beat that carries the last flag at channel index N-1. It is never high at any other time.
- R4: The result is computed in this order. First the bias (Q8.8, aligned to the product's 16 fraction bits) is added to the sum. The sum is then truncated toward minus infinity to Q8.8. Next it is multiplied by the Q8.8 scale and shifted right 8 with floor rounding. Finally the offset is added.
- R5: After the offset is added, the value saturates to the signed 16-bit range [-32768, 32767].
- R6: The activation code is taken from mode bits [1:0]. Code 0 passes the value unchanged. Code 1 clamps negative values to 0. Code 2 replaces a negative value v with v>>>3 (arithmetic shift). Code 3 behaves as code 0.
- R7: The channel count N is set at run time as N-1 in `ld_data[9:0]` and ranges from 1 to 1024. The channel index wraps to 0 after index N-1. Loading N restarts the channel index at 0.
- R8: A beat whose last flag disagrees with whether its index is N-1 raises `out_err` for one cycle, the cycle after that beat. This covers a last flag arriving early and a last flag missing at index N-1. No result is produced for that pixel, its partial sum is discarded, and the next beat is channel 0.
- R9: Mode bit 2 selects the source: 0 selects the raw stream and 1 selects the depthwise stream. The valid, data and last signals of the unselected stream have no effect.
- R10: When `ld_valid` is high, `ld_kind` selects what is written: 0 writes a weight at `ld_addr`, 1 the bias, 2 the scale, 3 the offset, 4 the channel count, 5 the mode. The new value is used from the next cycle on.
- R11: A cycle without a valid beat on the selected stream does not advance the channel index, does not change the sum, and produces neither `out_valid` nor `out_err` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Raw-channel beat valid |
| raw_data | input | 16 | Raw-channel value, Q8.8 |
| raw_last | input | 1 | Raw beat is the final channel of the pixel |
| dw_valid | input | 1 | Depthwise-result beat valid |
| dw_data | input | 16 | Depthwise-result value, Q8.8 |
| dw_last | input | 1 | Depthwise beat is the final channel of the pixel |
| ld_valid | input | 1 | Load strobe |
| ld_kind | input | 3 | Load target (see R10) |
| ld_addr | input | 10 | Weight address for kind 0 |
| ld_data | input | 16 | Load value |
| out_valid | output | 1 | Result valid, one cycle per pixel |
| out_data | output | 16 | Result, Q8.8 |
| out_err | output | 1 | Channel-count mismatch pulse |

## Verification
The bound checker verifies a number of properties on every cycle:
- The output and error pulses only ever follow an accepted beat, and the two never occur together.
- A result only follows a beat that carries the last flag.
- The channel index never passes N-1 and returns to zero after each last-flagged beat.
- Results are non-negative while the clamping activation is active.

The numerical value of each result, the order of the bias, scaling and offset, saturation, the leaky slope and the effect of selecting a source can only be shown by the bench scenarios. The bench checks these against its behavioural reference model, using random and boundary channel counts.

// File: rtl/pw_mac_pkg.sv
package pw_mac_pkg;

    localparam int DATA_W  = 16;
    localparam int FRAC_W  = 8;
    localparam int ACC_W   = 40;
    localparam int LEAK_SH = 3;

    typedef enum logic [2:0] {
        LD_WEIGHT = 3'd0,
        LD_BIAS   = 3'd1,
        LD_SCALE  = 3'd2,
        LD_OFFSET = 3'd3,
        LD_NCH    = 3'd4,
        LD_MODE   = 3'd5
    } ld_kind_e;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_RELU  = 2'd1,
        ACT_LEAKY = 2'd2,
        ACT_PASS3 = 2'd3
    } act_e;

    typedef struct packed {
        logic signed [DATA_W-1:0] bias;
        logic signed [DATA_W-1:0] scale;
        logic signed [DATA_W-1:0] offset;
        act_e                     act;
        logic                     src_dw;
    } tail_cfg_t;

    function automatic logic signed [DATA_W-1:0] act_apply(
        input act_e m, input logic signed [DATA_W-1:0] v);
        case (m)
            ACT_RELU:  return v[DATA_W-1] ? '0 : v;
            ACT_LEAKY: return v[DATA_W-1] ? (v >>> LEAK_SH) : v;
            default:   return v;
        endcase
    endfunction

endpackage

// File: rtl/pw_weight_ram.sv
module pw_weight_ram #(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [DW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [DW-1:0] rdata
);
    logic signed [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pw_accum.sv
module pw_accum #(
    parameter int AW  = 10,
    parameter int DW  = 16,
    parameter int ACC = 40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    input  logic                  beat,
    input  logic                  beat_last,
    input  logic signed [DW-1:0]  beat_data,
    input  logic signed [DW-1:0]  weight,
    input  logic [AW-1:0]         nm1,
    output logic [AW-1:0]         ch_idx,
    output logic signed [ACC-1:0] sum_next,
    output logic                  pix_done,
    output logic                  pix_err
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0]  prod;
    logic signed [ACC-1:0] acc;
    logic signed [ACC-1:0] base;
    logic                  at_end;

    assign prod     = beat_data * weight;
    assign base     = (ch_idx == '0) ? '0 : acc;
    assign sum_next = base + ACC'(prod);
    assign at_end   = (ch_idx == nm1);
    assign pix_done = beat && beat_last && at_end;
    assign pix_err  = beat && (beat_last != at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_idx <= '0;
            acc    <= '0;
        end else begin
            if (restart)
                ch_idx <= '0;
            else if (beat)
                ch_idx <= (at_end || beat_last) ? '0 : ch_idx + AW'(1);
            if (beat) acc <= sum_next;
        end
    end
endmodule

// File: rtl/pw_tail.sv
module pw_tail
    import pw_mac_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int FRAC = FRAC_W,
    parameter int ACC  = ACC_W
) (
    input  logic signed [ACC-1:0] sum,
    input  tail_cfg_t             cfg,
    output logic signed [DW-1:0]  result
);
    localparam int PRE_W = ACC - FRAC;
    localparam int MUL_W = PRE_W + DW;

    logic signed [ACC-1:0]   biased;
    logic signed [PRE_W-1:0] pre;
    logic signed [MUL_W-1:0] scaled;
    logic signed [MUL_W-1:0] normed;
    logic signed [MUL_W-1:0] hi_lim;
    logic signed [MUL_W-1:0] lo_lim;
    logic signed [DW-1:0]    clipped;

    assign biased = sum + (ACC'(cfg.bias) <<< FRAC);
    assign pre    = biased[ACC-1:FRAC];
    assign scaled = pre * cfg.scale;
    assign normed = (scaled >>> FRAC) + MUL_W'(cfg.offset);
    assign hi_lim = MUL_W'((2 ** (DW - 1)) - 1);
    assign lo_lim = -hi_lim - MUL_W'(1);

    always_comb begin
        if (normed > hi_lim)      clipped = hi_lim[DW-1:0];
        else if (normed < lo_lim) clipped = lo_lim[DW-1:0];
        else                      clipped = normed[DW-1:0];
        result = act_apply(cfg.act, clipped);
    end
endmodule

// File: rtl/pw_mac_unit.sv
module pw_mac_unit
    import pw_mac_pkg::*;
#(
    parameter int MAX_CH = 1024,
    localparam int AW    = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              raw_last,
    input  logic              dw_valid,
    input  logic [DATA_W-1:0] dw_data,
    input  logic              dw_last,
    input  logic              ld_valid,
    input  logic [2:0]        ld_kind,
    input  logic [AW-1:0]     ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err
);
    tail_cfg_t                cfg;
    logic [AW-1:0]            nm1;
    logic                     sel_valid;
    logic                     sel_last;
    logic signed [DATA_W-1:0] sel_data;
    logic signed [DATA_W-1:0] weight;
    logic [AW-1:0]            ch_idx;
    logic signed [ACC_W-1:0]  sum_next;
    logic                     pix_done;
    logic                     pix_err;
    logic signed [DATA_W-1:0] tail_res;
    logic                     wr_weight;
    logic                     wr_nch;
    ld_kind_e                 kind;

    assign kind      = ld_kind_e'(ld_kind);
    assign wr_weight = ld_valid && (kind == LD_WEIGHT);
    assign wr_nch    = ld_valid && (kind == LD_NCH);

    assign sel_valid = cfg.src_dw ? dw_valid : raw_valid;
    assign sel_last  = cfg.src_dw ? dw_last  : raw_last;
    assign sel_data  = cfg.src_dw ? $signed(dw_data) : $signed(raw_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.bias   <= '0;
            cfg.scale  <= 16'sh0100;
            cfg.offset <= '0;
            cfg.act    <= ACT_PASS;
            cfg.src_dw <= 1'b0;
            nm1        <= '0;
        end else if (ld_valid) begin
            case (kind)
                LD_BIAS:   cfg.bias   <= $signed(ld_data);
                LD_SCALE:  cfg.scale  <= $signed(ld_data);
                LD_OFFSET: cfg.offset <= $signed(ld_data);
                LD_NCH:    nm1        <= ld_data[AW-1:0];
                LD_MODE: begin
                    cfg.act    <= act_e'(ld_data[1:0]);
                    cfg.src_dw <= ld_data[2];
                end
                default: ;
            endcase
        end
    end

    pw_weight_ram #(.DEPTH(MAX_CH), .DW(DATA_W)) u_wram (
        .clk   (clk),
        .we    (wr_weight),
        .waddr (ld_addr),
        .wdata ($signed(ld_data)),
        .raddr (ch_idx),
        .rdata (weight)
    );

    pw_accum #(.AW(AW), .DW(DATA_W), .ACC(ACC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .restart   (wr_nch),
        .beat      (sel_valid),
        .beat_last (sel_last),
        .beat_data (sel_data),
        .weight    (weight),
        .nm1       (nm1),
        .ch_idx    (ch_idx),
        .sum_next  (sum_next),
        .pix_done  (pix_done),
        .pix_err   (pix_err)
    );

    pw_tail u_tail (
        .sum    (sum_next),
        .cfg    (cfg),
        .result (tail_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pix_done;
            out_err   <= pix_err;
            if (pix_done) out_data <= tail_res;
        end
    end
endmodule

// File: rtl/pw_mac_chk.sv
module pw_mac_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          beat,
    input logic          beat_last,
    input logic          out_valid,
    input logic          out_err,
    input logic [15:0]   out_data,
    input logic [1:0]    act,
    input logic [AW-1:0] idx,
    input logic [AW-1:0] nm1
);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !beat |=> (!out_valid && !out_err));

    assert_valid_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(beat && beat_last));

    assert_valid_err_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_err));

    assert_relu_nonneg_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(act) == 2'd1)) |-> !out_data[15]);

    assert_idx_bound_R7: assert property (@(posedge clk) disable iff (rst)
        idx <= nm1);

    assert_restart_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        (beat && beat_last) |=> (idx == '0));
endmodule

bind pw_mac_unit pw_mac_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .beat      (sel_valid),
    .beat_last (sel_last),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_data  (out_data),
    .act       (cfg.act),
    .idx       (ch_idx),
    .nm1       (nm1)
);

// File: tb/pw_mac_unit_tb.sv
module pw_mac_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raw_valid = 0, raw_last = 0, dw_valid = 0, dw_last = 0;
    logic [15:0] raw_data = 0, dw_data = 0;
    logic        ld_valid = 0;
    logic [2:0]  ld_kind = 0;
    logic [9:0]  ld_addr = 0;
    logic [15:0] ld_data = 0;
    logic        out_valid, out_err;
    logic [15:0] out_data;

    always #5 clk = ~clk;

    pw_mac_unit u_dut (
        .clk(clk), .rst(rst),
        .raw_valid(raw_valid), .raw_data(raw_data), .raw_last(raw_last),
        .dw_valid(dw_valid), .dw_data(dw_data), .dw_last(dw_last),
        .ld_valid(ld_valid), .ld_kind(ld_kind), .ld_addr(ld_addr), .ld_data(ld_data),
        .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
    );

    int total = 0, bad = 0;
    bit done = 0;
    string cur_req = "R1";
    bit junk = 0;

    // reference model state
    int     wmem [1024];
    int     m_idx = 0, m_nm1 = 0, m_bias = 0, m_scale = 256, m_off = 0, m_act = 0;
    bit     m_src = 0;
    longint m_acc = 0;
    bit     exp_v = 0, exp_err = 0;
    int     exp_d = 0;

    task automatic check(bit ok, string req, string what, int got, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, expv);
        end
    endtask

    function automatic int finish_ref(longint a);
        longint s, pre, n;
        s   = a + longint'(m_bias) * 256;
        pre = s >>> 8;
        n   = ((pre * longint'(m_scale)) >>> 8) + longint'(m_off);
        if (n > 32767)  n = 32767;
        if (n < -32768) n = -32768;
        if (m_act == 1 && n < 0) n = 0;
        if (m_act == 2 && n < 0) n = n >>> 3;
        return int'(n);
    endfunction

    task automatic model_step();
        bit bv, bl, hit;
        int bx;
        longint a;
        exp_v = 0; exp_err = 0;
        if (rst) begin
            m_idx = 0; m_nm1 = 0; m_bias = 0; m_scale = 256; m_off = 0;
            m_act = 0; m_src = 0; m_acc = 0; exp_d = 0;
            return;
        end
        bv = m_src ? dw_valid : raw_valid;
        bl = m_src ? dw_last  : raw_last;
        bx = m_src ? int'($signed(dw_data)) : int'($signed(raw_data));
        if (bv) begin
            hit = (m_idx == m_nm1);
            a = ((m_idx == 0) ? 64'sd0 : m_acc) + longint'(bx) * longint'(wmem[m_idx]);
            if (bl == hit) begin
                m_acc = a;
                if (bl) begin exp_v = 1; exp_d = finish_ref(a); m_idx = 0; end
                else m_idx++;
            end else begin
                exp_err = 1; m_idx = 0;
            end
        end
        if (ld_valid) begin
            case (ld_kind)
                3'd0: wmem[ld_addr] = int'($signed(ld_data));
                3'd1: m_bias  = int'($signed(ld_data));
                3'd2: m_scale = int'($signed(ld_data));
                3'd3: m_off   = int'($signed(ld_data));
                3'd4: begin m_nm1 = int'(ld_data[9:0]); m_idx = 0; end
                3'd5: begin m_act = int'(ld_data[1:0]); m_src = ld_data[2]; end
                default: ;
            endcase
        end
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        check(out_valid == exp_v, "R3", "out_valid", int'(out_valid), int'(exp_v));
        check(out_err == exp_err, "R8", "out_err", int'(out_err), int'(exp_err));
        if (exp_v && out_valid)
            check(int'($signed(out_data)) == exp_d, cur_req, "out_data",
                  int'($signed(out_data)), exp_d);
    endtask

    task automatic load(int kind, int addr, int data);
        ld_valid = 1; ld_kind = 3'(kind); ld_addr = 10'(addr); ld_data = 16'(data);
        cycle();
        ld_valid = 0;
    endtask

    task automatic beat(int x, bit last);
        if (m_src) begin
            dw_valid = 1; dw_data = 16'(x); dw_last = last;
            raw_valid = junk; raw_data = 16'($urandom); raw_last = junk & $urandom_range(1);
        end else begin
            raw_valid = 1; raw_data = 16'(x); raw_last = last;
            dw_valid = junk; dw_data = 16'($urandom); dw_last = junk & $urandom_range(1);
        end
        cycle();
        raw_valid = 0; dw_valid = 0; raw_last = 0; dw_last = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    function automatic int rnd_q(int span);
        return int'($urandom_range(2 * span)) - span;
    endfunction

    // drives one pixel of n channels; gaps inserts idle cycles between beats
    task automatic pixel(int n, bit gaps);
        for (int c = 0; c < n; c++) begin
            beat(rnd_q(2048), c == n - 1);
            if (gaps && $urandom_range(3) == 0) idle(1);
        end
        idle(1);
    endtask

    task automatic set_n(int n);
        load(4, 0, n - 1);
    endtask

    task automatic load_weights(int n);
        for (int i = 0; i < n; i++) load(0, i, rnd_q(2048));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R3 watchdog expired got=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state and defaults
        cur_req = "R1";
        idle(3);
        rst = 0;
        check(out_data == 16'd0, "R1", "out_data after reset", int'(out_data), 0);
        idle(2);
        load(0, 0, 256);
        beat(384, 1);   // N=1, scale 1.0, pass: result 384
        idle(1);

        // R2, R10, R11: N=4 with gaps, back-to-back pixels
        cur_req = "R2";
        set_n(4);
        load_weights(4);
        pixel(4, 1);
        pixel(4, 0);
        beat(100, 0); beat(200, 0); beat(300, 0); beat(-400, 1);
        cur_req = "R11";
        idle(3);
        pixel(4, 1);

        // R10 / R4: bias, scale, offset order
        cur_req = "R4";
        load(1, 0, 300);
        load(2, 0, -384);
        load(3, 0, 77);
        pixel(4, 0);
        load(2, 0, 129);
        load(1, 0, -5);
        pixel(4, 1);
        cur_req = "R10";
        load(0, 2, 0);
        pixel(4, 0);

        // R5: saturation both ways
        cur_req = "R5";
        load(2, 0, 16'h7fff);
        load(1, 0, 0); load(3, 0, 0);
        set_n(2);
        load(0, 0, 2047); load(0, 1, 2047);
        beat(2047, 0); beat(2047, 1);
        beat(-2047, 0); beat(-2047, 1);
        idle(1);

        // R6: activation codes
        cur_req = "R6";
        load(2, 0, 256);
        for (int m = 0; m < 4; m++) begin
            load(5, 0, m);
            beat(-1000, 0); beat(900, 1);
            beat(1000, 0); beat(-900, 1);
            pixel(2, 0);
        end

        // R8: early last, missing last, then recovery
        cur_req = "R8";
        load(5, 0, 0);
        set_n(5);
        load_weights(5);
        beat(10, 0); beat(20, 1);
        beat(1, 0); beat(2, 0); beat(3, 0); beat(4, 0); beat(5, 0);
        beat(7, 1);
        idle(1);
        pixel(5, 0);

        // R9: depthwise source, raw stream carries junk
        cur_req = "R9";
        load(5, 0, 4);
        junk = 1;
        pixel(5, 1);
        pixel(5, 0);
        junk = 0;
        load(5, 0, 1);
        junk = 1;
        pixel(5, 0);
        junk = 0;
        load(5, 0, 0);

        // R7: random channel counts and tail settings
        cur_req = "R7";
        for (int p = 0; p < 8; p++) begin
            int n;
            n = int'($urandom_range(1, 48));
            set_n(n);
            load_weights(n);
            load(1, 0, rnd_q(4000));
            load(2, 0, rnd_q(600));
            load(3, 0, rnd_q(4000));
            load(5, 0, int'($urandom_range(3)));
            pixel(n, p[0]);
            pixel(n, 0);
        end

        // R7 boundary: N=1, then N=1024 with wrap back to channel 0
        load(5, 0, 0); load(1, 0, 0); load(2, 0, 256); load(3, 0, 0);
        set_n(1);
        pixel(1, 0); pixel(1, 0);
        set_n(1024);
        load_weights(1024);
        pixel(1024, 0);
        beat(50, 0);
        set_n(1024);   // loading N restarts index
        pixel(1024, 0);
        idle(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule